// File: doc/BRIEF.md
# Run-Time Precision Significand Rounder

This block takes a normalised intermediate significand of 64 bits, plus two extra low-order bits (guard and round) and a sticky bit that summarises everything further down. It rounds the value to one of three significand widths chosen per operation: 24, 53 or 64 bits. It applies one of four IEEE 754 rounding directions, and the two directed modes take the operand sign into account. Each result carries the rounded significand with every bit below the chosen boundary cleared, a flag that asks the exponent path to add one when rounding overflows the significand, an inexact flag, and a flag for an unsupported precision code.

Operands arrive on a valid/ready stream and leave on a second valid/ready stream after one register stage. A result that is not taken stays on the output unchanged. The input side accepts a new operand in the same cycle that the consumer takes the pending result, so one operand per cycle flows through while `out_ready` stays high. When the consumer holds `out_ready` low with a result pending, `in_ready` drops and the producer must keep its operand until it is accepted.

Top module: `sig_rounder`

## Requirements
- R1: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, every output stays unchanged and no new operand is taken.
- R2: Mode code 01 (toward zero) truncates. It never increments the kept significand and never raises `out_exp_inc`.
- R3: Mode code 00 (to nearest) increments when the first discarded bit is 1 and either a lower discarded bit is 1 or the kept LSB is 1. An exact half-way value therefore goes to the even neighbour.
- R4: Mode code 11 (toward plus infinity) increments only when `in_sign` is 0 and some discarded bit is 1. Mode code 10 (toward minus infinity) increments only when `in_sign` is 1 and some discarded bit is 1.
- R5: Precision code 01 keeps `in_sig[63:40]`, code 10 keeps `in_sig[63:11]`, and code 00 keeps all of `in_sig[63:0]`, with guard, round and sticky always discarded. Output bits below the kept field are 0.
- R6: Precision code 11 rounds exactly as code 00 and raises `out_bad_prec`. Every other code leaves `out_bad_prec` low.
- R7: If the increment carries out of bit 63, `out_sig` is 0x8000_0000_0000_0000 and `out_exp_inc` is 1. Otherwise `out_exp_inc` is 0.
- R8: `out_inexact` is 1 exactly when a discarded bit of `in_sig`, or guard, round or sticky, is 1.
- R9: After reset `out_valid` is 0 and `in_ready` is 1.
- R10: An operand accepted at a clock edge is presented on the outputs with `out_valid` high right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Operand can be taken this cycle |
| in_sign | input | 1 | Sign of the value being rounded |
| in_sig | input | 64 | Intermediate significand, MSB at bit 63 |
| in_guard | input | 1 | First bit below `in_sig[0]` |
| in_round | input | 1 | Second bit below `in_sig[0]` |
| in_sticky | input | 1 | OR of all bits below the round bit |
| in_mode | input | 2 | Rounding direction: 00 nearest, 01 zero, 10 minus infinity, 11 plus infinity |
| in_prec | input | 2 | Precision: 00 64-bit, 01 24-bit, 10 53-bit, 11 unsupported |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_sig | output | 64 | Rounded significand |
| out_exp_inc | output | 1 | Rounding overflowed the significand |
| out_inexact | output | 1 | A nonzero bit was discarded |
| out_bad_prec | output | 1 | Precision code 11 was seen |

## Verification
The bench aims at exact half-way values with both kept-LSB parities. A rounder that rounds half up, or that ignores the sticky bit, lands on the odd neighbour or misses the increment. It drives all-ones kept fields at every width, where a missing carry fix-up returns zero instead of 1.000… and leaves the exponent flag low. It sets nonzero bits only in guard, round or sticky, where a rounder that looks only at `in_sig` reports an exact result. It also runs directed modes with both signs, code 11, and a stalled consumer, catching sign-swapped increments, precision code 11 falling to a shorter width, and results that change or are overwritten while they wait.

// File: rtl/sig_round_pkg.sv
package sig_round_pkg;
  typedef enum logic [1:0] {
    RD_NEAREST = 2'b00,
    RD_ZERO    = 2'b01,
    RD_NEG_INF = 2'b10,
    RD_POS_INF = 2'b11
  } rdir_e;

  typedef enum logic [1:0] {
    PW_WIDE   = 2'b00,
    PW_NARROW = 2'b01,
    PW_MID    = 2'b10,
    PW_BAD    = 2'b11
  } pwidth_e;

  typedef struct packed {
    logic lsb;
    logic half;
    logic rest;
  } tail_t;

  localparam int NUM_WIDTHS = 3;
endpackage

// File: rtl/sig_tail_pick.sv
module sig_tail_pick
  import sig_round_pkg::*;
#(
  parameter int SIG_W  = 64,
  parameter int KEEP_W = 24
) (
  input  logic [SIG_W-1:0] sig,
  input  logic             guard,
  input  logic             rnd,
  input  logic             sticky,
  output tail_t            tail,
  output logic [SIG_W-1:0] keep_mask,
  output logic [SIG_W-1:0] unit
);
  localparam int EW   = SIG_W + 2;
  localparam int DROP = SIG_W - KEEP_W;
  localparam logic [SIG_W-1:0] ONES = '1;
  localparam logic [SIG_W-1:0] ONE  = {{(SIG_W-1){1'b0}}, 1'b1};

  logic [EW-1:0] ext;
  assign ext = {sig, guard, rnd};

  assign tail.lsb  = ext[EW-KEEP_W];
  assign tail.half = ext[EW-KEEP_W-1];
  assign tail.rest = (|ext[EW-KEEP_W-2:0]) | sticky;

  assign keep_mask = ONES << DROP;
  assign unit      = ONE << DROP;
endmodule

// File: rtl/sig_point_mux.sv
module sig_point_mux
  import sig_round_pkg::*;
#(
  parameter int SIG_W = 64,
  parameter int SGL_W = 24,
  parameter int DBL_W = 53
) (
  input  logic [SIG_W-1:0] sig,
  input  logic             guard,
  input  logic             rnd,
  input  logic             sticky,
  input  logic [1:0]       prec,
  output tail_t            tail,
  output logic [SIG_W-1:0] keep_mask,
  output logic [SIG_W-1:0] unit,
  output logic             bad_prec
);
  // index 0 = full width, 1 = narrow, 2 = mid; matches the precision code
  localparam int KW [NUM_WIDTHS] = '{SIG_W, SGL_W, DBL_W};

  tail_t            tails [NUM_WIDTHS];
  logic [SIG_W-1:0] masks [NUM_WIDTHS];
  logic [SIG_W-1:0] units [NUM_WIDTHS];

  for (genvar i = 0; i < NUM_WIDTHS; i++) begin : g_width
    sig_tail_pick #(.SIG_W(SIG_W), .KEEP_W(KW[i])) u_pick (
      .sig       (sig),
      .guard     (guard),
      .rnd       (rnd),
      .sticky    (sticky),
      .tail      (tails[i]),
      .keep_mask (masks[i]),
      .unit      (units[i])
    );
  end

  logic [1:0] idx;
  assign bad_prec = (prec == PW_BAD);
  assign idx      = bad_prec ? 2'd0 : prec;

  always_comb begin
    tail      = tails[0];
    keep_mask = masks[0];
    unit      = units[0];
    for (int i = 1; i < NUM_WIDTHS; i++) begin
      if (int'(idx) == i) begin
        tail      = tails[i];
        keep_mask = masks[i];
        unit      = units[i];
      end
    end
  end
endmodule

// File: rtl/sig_round_decide.sv
module sig_round_decide
  import sig_round_pkg::*;
(
  input  logic       sign,
  input  logic [1:0] mode,
  input  tail_t      tail,
  output logic       inc,
  output logic       inexact
);
  assign inexact = tail.half | tail.rest;

  always_comb begin
    unique case (rdir_e'(mode))
      RD_NEAREST: inc = tail.half & (tail.rest | tail.lsb);
      RD_ZERO:    inc = 1'b0;
      RD_NEG_INF: inc = sign & inexact;
      RD_POS_INF: inc = ~sign & inexact;
      default:    inc = 1'b0;
    endcase
  end
endmodule

// File: rtl/sig_out_stage.sv
module sig_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = ~out_valid | out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/sig_rounder.sv
module sig_rounder
  import sig_round_pkg::*;
#(
  parameter int SIG_W = 64,
  parameter int SGL_W = 24,
  parameter int DBL_W = 53
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_sign,
  input  logic [SIG_W-1:0] in_sig,
  input  logic             in_guard,
  input  logic             in_round,
  input  logic             in_sticky,
  input  logic [1:0]       in_mode,
  input  logic [1:0]       in_prec,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [SIG_W-1:0] out_sig,
  output logic             out_exp_inc,
  output logic             out_inexact,
  output logic             out_bad_prec
);
  localparam int PW = SIG_W + 3;

  tail_t            tail;
  logic [SIG_W-1:0] keep_mask, unit;
  logic             bad_prec, inc, inexact;

  sig_point_mux #(.SIG_W(SIG_W), .SGL_W(SGL_W), .DBL_W(DBL_W)) u_point (
    .sig       (in_sig),
    .guard     (in_guard),
    .rnd       (in_round),
    .sticky    (in_sticky),
    .prec      (in_prec),
    .tail      (tail),
    .keep_mask (keep_mask),
    .unit      (unit),
    .bad_prec  (bad_prec)
  );

  sig_round_decide u_decide (
    .sign    (in_sign),
    .mode    (in_mode),
    .tail    (tail),
    .inc     (inc),
    .inexact (inexact)
  );

  logic [SIG_W:0]   sum;
  logic             carry;
  logic [SIG_W-1:0] rounded;

  assign sum     = {1'b0, in_sig & keep_mask} + (inc ? {1'b0, unit} : '0);
  assign carry   = sum[SIG_W];
  assign rounded = carry ? {1'b1, {(SIG_W-1){1'b0}}} : sum[SIG_W-1:0];

  logic [PW-1:0] pay_in, pay_out;
  assign pay_in = {rounded, carry, inexact, bad_prec};

  sig_out_stage #(.W(PW)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (pay_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (pay_out)
  );

  assign out_sig      = pay_out[PW-1:3];
  assign out_exp_inc  = pay_out[2];
  assign out_inexact  = pay_out[1];
  assign out_bad_prec = pay_out[0];
endmodule

// File: rtl/sig_rounder_chk.sv
module sig_rounder_chk #(
  parameter int SIG_W = 64,
  parameter int SGL_W = 24,
  parameter int DBL_W = 53
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_sig_top,
  input logic [1:0]       in_mode,
  input logic [1:0]       in_prec,
  input logic             in_exact_ext,
  input logic [SIG_W-1:0] in_sig,
  input logic             out_valid,
  input logic             out_ready,
  input logic [SIG_W-1:0] out_sig,
  input logic             out_exp_inc,
  input logic             out_inexact,
  input logic             out_bad_prec
);
  logic take;
  assign take = in_valid && in_ready;

  // R1
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sig)
      && $stable(out_exp_inc) && $stable(out_inexact) && $stable(out_bad_prec)));

  // R1
  ready_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R7
  carry_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_exp_inc) |-> (out_sig == {1'b1, {(SIG_W-1){1'b0}}}));

  // R2
  zero_noinc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_mode == 2'b01) |=> (!out_exp_inc && out_sig == ($past(in_sig) & out_sig)));

  // R5
  narrow_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_prec == 2'b01) |=> (out_sig[SIG_W-SGL_W-1:0] == '0));

  // R5
  mid_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_prec == 2'b10) |=> (out_sig[SIG_W-DBL_W-1:0] == '0));

  // R6
  bad_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (out_bad_prec == ($past(in_prec) == 2'b11)));

  // R8
  exact_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_exact_ext && (in_prec == 2'b00 || in_prec == 2'b11))
      |=> (!out_inexact && out_sig == $past(in_sig)));

  // R10
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  logic unused_top;
  assign unused_top = in_sig_top;
endmodule

bind sig_rounder sig_rounder_chk #(.SIG_W(SIG_W), .SGL_W(SGL_W), .DBL_W(DBL_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .in_sig_top   (in_sig[SIG_W-1]),
  .in_mode      (in_mode),
  .in_prec      (in_prec),
  .in_exact_ext (!(in_guard || in_round || in_sticky)),
  .in_sig       (in_sig),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_sig      (out_sig),
  .out_exp_inc  (out_exp_inc),
  .out_inexact  (out_inexact),
  .out_bad_prec (out_bad_prec)
);

// File: tb/sim_sig_rounder.sv
module sim_sig_rounder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_sign = 1'b0;
  logic [63:0] in_sig = '0;
  logic        in_guard = 1'b0, in_round = 1'b0, in_sticky = 1'b0;
  logic [1:0]  in_mode = 2'b00, in_prec = 2'b00;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_sig;
  logic        out_exp_inc, out_inexact, out_bad_prec;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sig_rounder u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sign(in_sign), .in_sig(in_sig), .in_guard(in_guard), .in_round(in_round),
    .in_sticky(in_sticky), .in_mode(in_mode), .in_prec(in_prec),
    .out_valid(out_valid), .out_ready(out_ready), .out_sig(out_sig),
    .out_exp_inc(out_exp_inc), .out_inexact(out_inexact), .out_bad_prec(out_bad_prec)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Reference: treat {sig, g, r, s} as one 67-bit value and keep the top w bits.
  function automatic void model(input logic sgn, input logic [63:0] sig,
      input logic g, input logic r, input logic s, input logic [1:0] mode,
      input logic [1:0] prec, output logic [63:0] esig, output logic einc,
      output logic einx, output logic ebad);
    int w;
    int n;
    logic [66:0] v, kept, low, below;
    logic half, up;
    w = (prec == 2'b01) ? 24 : (prec == 2'b10) ? 53 : 64;
    n = 67 - w;
    v = {sig, g, r, s};
    kept = v >> n;
    low = v & ((67'd1 << n) - 67'd1);
    half = low[n-1];
    below = low & ((67'd1 << (n-1)) - 67'd1);
    einx = (low != 0);
    case (mode)
      2'b00: up = half && (below != 0 || kept[0]);
      2'b01: up = 1'b0;
      2'b10: up = sgn && einx;
      default: up = !sgn && einx;
    endcase
    kept = kept + {66'd0, up};
    if ((kept >> w) != 0) begin
      esig = 64'h8000_0000_0000_0000;
      einc = 1'b1;
    end else begin
      esig = 64'(kept << (64 - w));
      einc = 1'b0;
    end
    ebad = (prec == 2'b11);
  endfunction

  task automatic run(input logic sgn, input logic [63:0] sig, input logic g,
                     input logic r, input logic s, input logic [1:0] mode,
                     input logic [1:0] prec);
    logic [63:0] es;
    logic ei, ex, eb;
    string mtag;
    model(sgn, sig, g, r, s, mode, prec, es, ei, ex, eb);
    mtag = (mode == 2'b00) ? "R3" : (mode == 2'b01) ? "R2" : "R4";
    @(negedge clk);
    in_sign = sgn; in_sig = sig; in_guard = g; in_round = r; in_sticky = s;
    in_mode = mode; in_prec = prec; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1, "R10", "out_valid after accept", 64'(out_valid), 64'd1);
    check(out_sig == es, (prec == 2'b11) ? "R6" : mtag, "out_sig (R5 boundary)", out_sig, es);
    check(out_exp_inc == ei, "R7", "out_exp_inc", 64'(out_exp_inc), 64'(ei));
    check(out_inexact == ex, "R8", "out_inexact", 64'(out_inexact), 64'(ex));
    check(out_bad_prec == eb, "R6", "out_bad_prec", 64'(out_bad_prec), 64'(eb));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] a_sig;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9
    check(out_valid == 1'b0, "R9", "out_valid in reset", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R9", "valid/ready after reset",
          {62'd0, out_valid, in_ready}, 64'd1);

    // R3 ties to even, full width: LSB 0 stays, LSB 1 goes up
    run(1'b0, 64'hC000_0000_0000_0002, 1'b1, 1'b0, 1'b0, 2'b00, 2'b00);
    run(1'b0, 64'hC000_0000_0000_0003, 1'b1, 1'b0, 1'b0, 2'b00, 2'b00);
    // R3 tie broken by sticky alone
    run(1'b0, 64'hC000_0000_0000_0002, 1'b1, 1'b0, 1'b1, 2'b00, 2'b00);
    // R3 narrow width tie: bit 39 set, below zero, bit 40 even
    run(1'b0, 64'hA000_0080_0000_0000, 1'b0, 1'b0, 1'b0, 2'b00, 2'b01);
    // R7 carry at every width
    run(1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, 1'b0, 2'b00, 2'b00);
    run(1'b0, 64'hFFFF_FF80_0000_0000, 1'b0, 1'b0, 1'b0, 2'b00, 2'b01);
    run(1'b0, 64'hFFFF_FFFF_FFFF_FC00, 1'b0, 1'b0, 1'b0, 2'b00, 2'b10);
    // R4 sign dependence, R8 inexact from sticky only
    run(1'b0, 64'h8000_0000_0000_0000, 1'b0, 1'b0, 1'b1, 2'b11, 2'b00);
    run(1'b1, 64'h8000_0000_0000_0000, 1'b0, 1'b0, 1'b1, 2'b11, 2'b00);
    run(1'b1, 64'h8000_0000_0000_0000, 1'b0, 1'b0, 1'b1, 2'b10, 2'b00);
    run(1'b0, 64'h8000_0000_0000_0000, 1'b0, 1'b0, 1'b1, 2'b10, 2'b00);
    // R2 truncation on all-ones
    run(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b1, 1'b1, 2'b01, 2'b10);
    // R6 code 11 behaves as full width
    run(1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b1, 1'b0, 2'b00, 2'b11);
    run(1'b0, 64'h8123_4567_89AB_CDEF, 1'b0, 1'b0, 1'b0, 2'b11, 2'b11);

    // R1 back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    in_sign = 1'b0; in_sig = 64'h9000_0000_0000_0001; in_guard = 1'b1;
    in_round = 1'b1; in_sticky = 1'b0; in_mode = 2'b00; in_prec = 2'b00;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    a_sig = out_sig;
    check(in_ready == 1'b0, "R1", "in_ready while stalled", 64'(in_ready), 64'd0);
    in_sig = 64'hAAAA_0000_0000_0000; in_guard = 1'b0; in_round = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(out_valid && out_sig == 64'h9000_0000_0000_0002, "R1", "held result",
          out_sig, 64'h9000_0000_0000_0002);
    check(out_sig == a_sig && in_ready == 1'b0, "R1", "no overwrite", out_sig, a_sig);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_sig == 64'hAAAA_0000_0000_0000, "R1", "second after release",
          out_sig, 64'hAAAA_0000_0000_0000);
    @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "drained", 64'(out_valid), 64'd0);

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] s;
      logic [1:0] p, m;
      int sel;
      s = {$urandom, $urandom};
      s[63] = 1'b1;
      p = 2'($urandom);
      m = 2'($urandom);
      sel = $urandom % 4;
      if (sel == 0) s[62:0] = '1;
      else if (sel == 1) begin
        // make a half-way pattern at the chosen boundary
        if (p == 2'b01) begin s[39] = 1'b1; s[38:0] = '0; end
        else if (p == 2'b10) begin s[10] = 1'b1; s[9:0] = '0; end
      end
      if (sel == 1 && (p == 2'b00 || p == 2'b11))
        run(1'($urandom), s, 1'b1, 1'b0, 1'b0, m, p);
      else if (sel == 1)
        run(1'($urandom), s, 1'b0, 1'b0, 1'b0, m, p);
      else
        run(1'($urandom), s, 1'($urandom), 1'($urandom), 1'($urandom), m, p);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule